// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a page directory and a page table that live in ordinary memory. A requester presents an address with a write flag and a user flag. The block also samples a set of control inputs at acceptance: paging enable, supervisor write-protect enable, large-page enable, the directory base and an address mask. It then fetches the entries it needs over a simple request/ready memory port. It ends each walk either with a one-cycle `done` pulse and a physical address plus read, write and execute permissions, or with a one-cycle `fault` pulse and a three-bit error code plus the faulting address.

During the walk the block keeps the tables' bookkeeping up to date. It sets the accessed bit (bit 5) of entries it uses and the dirty bit (bit 6) of the final entry on a write. A memory write is issued only when one of those bits actually changes. Write permission is granted only when the final entry is dirty once the walk ends, so a later read of a clean page does not open it for writing. Directory entries with bit 7 set map 4 MB pages when large pages are enabled.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled, an accepted request completes with physical address = virtual address AND mask, read/write/execute all 1, and no memory access.
- R2: The first access reads the word at ((base with bits 11:0 cleared) + 4 × vaddr[31:22]) AND mask.
- R3: A table read uses address ((directory entry with bits 11:0 cleared) + 4 × vaddr[21:12]) AND mask.
- R4: A fetched entry with bit 0 (present) clear ends the walk with a fault whose error code bit 0 is 0.
- R5: A directory entry with bit 7 set, while large pages are enabled, ends the walk at the directory: physical = {entry[31:22], vaddr[21:0]} AND mask. With large pages disabled, bit 7 is ignored and the walk continues to the table.
- R6: A 4 KB translation gives physical = {table entry[31:12], vaddr[11:0]} AND mask. Its effective user bit (bit 2) and writable bit (bit 1) are the AND of the two entries.
- R7: A user access faults when the effective user bit is 0, or when it is a write and the effective writable bit is 0. A supervisor write faults on writable = 0 only while write-protect is enabled.
- R8: The error code is {user, write, protection}: bit 2 is user, bit 1 is write, and bit 0 is 1 for a permission failure. The fault address output holds the virtual address; permissions read 0 after a fault.
- R9: On a 4 KB walk, the directory entry is rewritten with bit 5 set if it was clear. The final entry is rewritten with bit 5 set, and bit 6 set on a write, only if this changes it. Writes go back to the address the entry was read from.
- R10: On success, read and execute are 1. Write is 1 only if the final entry is dirty after the walk and writing is allowed: for a user access, effective writable = 1; for a supervisor access, write-protect off or writable = 1.
- R11: `busy` is high from the cycle after acceptance through the response cycle and low afterwards. Requests are ignored while busy, and `done`/`fault` are single-cycle pulses.
- R12: While `memReq` is high and `memReady` is low, the request, address, write flag and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request, taken when idle |
| reqAddr | input | 32 | Virtual address |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user privilege |
| pagingOn | input | 1 | Paging enable |
| wpOn | input | 1 | Supervisor write-protect enable |
| largeOn | input | 1 | 4 MB page enable |
| dirBase | input | 32 | Directory base address |
| a20Mask | input | 32 | Mask applied to all physical addresses |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Successful translation pulse |
| fault | output | 1 | Page fault pulse |
| physAddr | output | 32 | Translated physical address |
| permRead | output | 1 | Read allowed |
| permWrite | output | 1 | Write allowed |
| permExec | output | 1 | Execute allowed |
| faultCode | output | 3 | Error code {user, write, protection} |
| faultAddr | output | 32 | Faulting virtual address |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memReady |
| memReady | input | 1 | Memory accepts or returns the access |

## Verification
The bench builds the walker with its default 32-bit address width, 4 KB page offset and 10-bit directory and table indexes. These are the only values the entry formats allow, and they put every directory and table field, the 4 MB frame split and the mask on bit 20 within reach. Its memory model holds 4096 words and wraps higher addresses onto them. Random 32-bit entries and bases therefore land in the same small image, and aliasing between a directory write-back and a following table read gets exercised. Random ready delays of zero to two cycles stall each access.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  // Entry bit positions (decoded by the tables' owner, so fixed)
  localparam int ENT_PRESENT  = 0;
  localparam int ENT_WRITABLE = 1;
  localparam int ENT_USER     = 2;
  localparam int ENT_ACCESSED = 5;
  localparam int ENT_DIRTY    = 6;
  localparam int ENT_LARGE    = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_CHK,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_CHK,
    ST_TBL_WB,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic capReq;     // latch request and control inputs
    logic latchFlat;  // identity result (paging off)
    logic capDir;     // latch directory entry from memory
    logic capTbl;     // latch table entry from memory
    logic memSelTbl;  // memory port addresses the table entry
    logic latchMap;   // latch translated result
    logic latchFault; // latch fault code and address
    logic faultProt;  // fault is a permission failure
  } walkStrobe_t;

  // Datapath -> control status
  typedef struct packed {
    logic dirPresent;
    logic dirLarge;
    logic dirAccessed;
    logic dirProtFail;
    logic dirNeedWb;
    logic tblPresent;
    logic tblProtFail;
    logic tblNeedWb;
  } walkStatus_t;

  function automatic logic denyAccess(input logic entU, input logic entW,
                                      input logic isUser, input logic isWrite,
                                      input logic wpEn);
    if (isUser) return !entU || (isWrite && !entW);
    return wpEn && isWrite && !entW;
  endfunction

  function automatic logic mayWrite(input logic entW, input logic isUser,
                                    input logic wpEn);
    if (isUser) return entW;
    return !wpEn || entW;
  endfunction

endpackage

// File: rtl/walk_dpath.sv
module walk_dpath
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  output walkStatus_t       stat,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              wpOn,
  input  logic              largeOn,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] a20Mask,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] physAddr,
  output logic              permRead,
  output logic              permWrite,
  output logic              permExec,
  output logic [2:0]        faultCode,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int ENT_LOG = $clog2(ADDR_W / 8);
  localparam int IDX_W   = (ADDR_W - OFF_W) / 2;
  localparam int DIR_LSB = OFF_W + IDX_W;
  localparam int PAD_W   = ADDR_W - IDX_W - ENT_LOG;
  localparam logic [ADDR_W-1:0] FRAME_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] SET_A      = ADDR_W'(1) << ENT_ACCESSED;
  localparam logic [ADDR_W-1:0] SET_D      = ADDR_W'(1) << ENT_DIRTY;

  logic [ADDR_W-1:0] vaR, baseR, a20R, pdeR, pteR;
  logic              wrR, usR, wpR, lgR;

  logic [ADDR_W-1:0] dirAddr, tblAddr, dirWb, tblWb;
  logic              isLarge, effU, effW;

  assign isLarge = pdeR[ENT_LARGE] & lgR;
  assign effU    = pdeR[ENT_USER] & pteR[ENT_USER];
  assign effW    = pdeR[ENT_WRITABLE] & pteR[ENT_WRITABLE];

  assign dirAddr = ((baseR & FRAME_MASK) +
                    {{PAD_W{1'b0}}, vaR[ADDR_W-1:DIR_LSB], {ENT_LOG{1'b0}}}) & a20R;
  assign tblAddr = ((pdeR & FRAME_MASK) +
                    {{PAD_W{1'b0}}, vaR[DIR_LSB-1:OFF_W], {ENT_LOG{1'b0}}}) & a20R;

  // Dirty is set on the directory only when it is the final (large) entry
  assign dirWb = pdeR | SET_A | ((isLarge && wrR) ? SET_D : '0);
  assign tblWb = pteR | SET_A | (wrR ? SET_D : '0);

  assign memAddr  = strb.memSelTbl ? tblAddr : dirAddr;
  assign memWdata = strb.memSelTbl ? tblWb : dirWb;

  always_comb begin
    stat             = '0;
    stat.dirPresent  = pdeR[ENT_PRESENT];
    stat.dirLarge    = isLarge;
    stat.dirAccessed = pdeR[ENT_ACCESSED];
    stat.dirProtFail = denyAccess(pdeR[ENT_USER], pdeR[ENT_WRITABLE], usR, wrR, wpR);
    stat.dirNeedWb   = !pdeR[ENT_ACCESSED] || (wrR && !pdeR[ENT_DIRTY]);
    stat.tblPresent  = pteR[ENT_PRESENT];
    stat.tblProtFail = denyAccess(effU, effW, usR, wrR, wpR);
    stat.tblNeedWb   = !pteR[ENT_ACCESSED] || (wrR && !pteR[ENT_DIRTY]);
  end

  // Final result computed from the entries as they stand after write-back
  logic [ADDR_W-1:0] mapPhys;
  logic              mapWrite;

  always_comb begin
    if (isLarge) begin
      mapPhys  = {pdeR[ADDR_W-1:DIR_LSB], vaR[DIR_LSB-1:0]} & a20R;
      mapWrite = (pdeR[ENT_DIRTY] | wrR) & mayWrite(pdeR[ENT_WRITABLE], usR, wpR);
    end else begin
      mapPhys  = {pteR[ADDR_W-1:OFF_W], vaR[OFF_W-1:0]} & a20R;
      mapWrite = (pteR[ENT_DIRTY] | wrR) & mayWrite(effW, usR, wpR);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR       <= '0;
      baseR     <= '0;
      a20R      <= '0;
      pdeR      <= '0;
      pteR      <= '0;
      wrR       <= 1'b0;
      usR       <= 1'b0;
      wpR       <= 1'b0;
      lgR       <= 1'b0;
      physAddr  <= '0;
      permRead  <= 1'b0;
      permWrite <= 1'b0;
      permExec  <= 1'b0;
      faultCode <= '0;
      faultAddr <= '0;
    end else begin
      if (strb.capReq) begin
        vaR   <= reqAddr;
        wrR   <= reqWrite;
        usR   <= reqUser;
        wpR   <= wpOn;
        lgR   <= largeOn;
        baseR <= dirBase;
        a20R  <= a20Mask;
      end
      if (strb.capDir) pdeR <= memRdata;
      if (strb.capTbl) pteR <= memRdata;
      if (strb.latchFlat) begin
        physAddr  <= reqAddr & a20Mask;
        permRead  <= 1'b1;
        permWrite <= 1'b1;
        permExec  <= 1'b1;
      end
      if (strb.latchMap) begin
        physAddr  <= mapPhys;
        permRead  <= 1'b1;
        permWrite <= mapWrite;
        permExec  <= 1'b1;
      end
      if (strb.latchFault) begin
        faultCode <= {usR, wrR, strb.faultProt};
        faultAddr <= vaR;
        permRead  <= 1'b0;
        permWrite <= 1'b0;
        permExec  <= 1'b0;
      end
    end
  end

  // R8
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchFault |=> (faultAddr == $past(vaR)) && (faultCode[0] == $past(strb.faultProt)));

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        pagingOn,
  input  logic        memReady,
  input  walkStatus_t stat,
  output walkStrobe_t strb,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic        memReq,
  output logic        memWe
);

  walkState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);
  assign fault  = (state == ST_FAULT);
  assign memWe  = (state == ST_DIR_WB) || (state == ST_TBL_WB);
  assign memReq = (state == ST_DIR_RD) || (state == ST_TBL_RD) || memWe;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capReq = 1'b1;
          if (!pagingOn) begin
            strb.latchFlat = 1'b1;
            stateNext      = ST_DONE;
          end else begin
            stateNext = ST_DIR_RD;
          end
        end
      end
      ST_DIR_RD: begin
        if (memReady) begin
          strb.capDir = 1'b1;
          stateNext   = ST_DIR_CHK;
        end
      end
      ST_DIR_CHK: begin
        if (!stat.dirPresent) begin
          strb.latchFault = 1'b1;
          stateNext       = ST_FAULT;
        end else if (stat.dirLarge) begin
          if (stat.dirProtFail) begin
            strb.latchFault = 1'b1;
            strb.faultProt  = 1'b1;
            stateNext       = ST_FAULT;
          end else if (stat.dirNeedWb) begin
            stateNext = ST_DIR_WB;
          end else begin
            strb.latchMap = 1'b1;
            stateNext     = ST_DONE;
          end
        end else if (!stat.dirAccessed) begin
          stateNext = ST_DIR_WB;
        end else begin
          stateNext = ST_TBL_RD;
        end
      end
      ST_DIR_WB: begin
        if (memReady) begin
          if (stat.dirLarge) begin
            strb.latchMap = 1'b1;
            stateNext     = ST_DONE;
          end else begin
            stateNext = ST_TBL_RD;
          end
        end
      end
      ST_TBL_RD: begin
        strb.memSelTbl = 1'b1;
        if (memReady) begin
          strb.capTbl = 1'b1;
          stateNext   = ST_TBL_CHK;
        end
      end
      ST_TBL_CHK: begin
        strb.memSelTbl = 1'b1;
        if (!stat.tblPresent) begin
          strb.latchFault = 1'b1;
          stateNext       = ST_FAULT;
        end else if (stat.tblProtFail) begin
          strb.latchFault = 1'b1;
          strb.faultProt  = 1'b1;
          stateNext       = ST_FAULT;
        end else if (stat.tblNeedWb) begin
          stateNext = ST_TBL_WB;
        end else begin
          strb.latchMap = 1'b1;
          stateNext     = ST_DONE;
        end
      end
      ST_TBL_WB: begin
        strb.memSelTbl = 1'b1;
        if (memReady) begin
          strb.latchMap = 1'b1;
          stateNext     = ST_DONE;
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  // R11
  resp_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |=> !busy);

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> memReq);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              pagingOn,
  input  logic              wpOn,
  input  logic              largeOn,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] a20Mask,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] physAddr,
  output logic              permRead,
  output logic              permWrite,
  output logic              permExec,
  output logic [2:0]        faultCode,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata,
  input  logic              memReady
);

  walkStrobe_t strb;
  walkStatus_t stat;

  walk_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .pagingOn (pagingOn),
    .memReady (memReady),
    .stat     (stat),
    .strb     (strb),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  walk_dpath #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .stat      (stat),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqUser   (reqUser),
    .wpOn      (wpOn),
    .largeOn   (largeOn),
    .dirBase   (dirBase),
    .a20Mask   (a20Mask),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .physAddr  (physAddr),
    .permRead  (permRead),
    .permWrite (permWrite),
    .permExec  (permExec),
    .faultCode (faultCode),
    .faultAddr (faultAddr)
  );

  // R12
  mem_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R9
  wb_accessed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> memWdata[ENT_ACCESSED]);

  // R10
  done_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (permRead && permExec));

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int LOG_MAX    = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqUser;
  logic [31:0] reqAddr;
  logic        pagingOn, wpOn, largeOn;
  logic [31:0] dirBase, a20Mask;
  logic        busy, done, fault;
  logic [31:0] physAddr, faultAddr;
  logic        permRead, permWrite, permExec;
  logic [2:0]  faultCode;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .pagingOn(pagingOn), .wpOn(wpOn),
    .largeOn(largeOn), .dirBase(dirBase), .a20Mask(a20Mask), .busy(busy),
    .done(done), .fault(fault), .physAddr(physAddr), .permRead(permRead),
    .permWrite(permWrite), .permExec(permExec), .faultCode(faultCode),
    .faultAddr(faultAddr), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  logic [31:0] mem    [MEM_WORDS];
  logic [31:0] refMem [MEM_WORDS];

  int checks = 0;
  int failures = 0;

  // expected outcome
  logic        expDone, expFault, expR, expW, expX;
  logic [31:0] expPhys, expFaddr;
  logic [2:0]  expCode;
  int          expN;
  logic [31:0] expAddr [LOG_MAX];
  logic        expWe   [LOG_MAX];
  logic [31:0] expData [LOG_MAX];

  // observed accesses
  int          actN;
  logic [31:0] actAddr [LOG_MAX];
  logic        actWe   [LOG_MAX];
  logic [31:0] actData [LOG_MAX];
  int          waitCnt = 0;

  function automatic int widx(input logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: decides ready away from the clock edge
  always @(negedge clk) begin
    if (memReq === 1'b1) begin
      if (waitCnt == 0) begin
        memReady = 1'b1;
        memRdata = mem[widx(memAddr)];
        if (memWe) mem[widx(memAddr)] = memWdata;
        if (actN < LOG_MAX) begin
          actAddr[actN] = memAddr;
          actWe[actN]   = memWe;
          actData[actN] = memWdata;
        end
        actN++;
        waitCnt = $urandom % 3;
      end else begin
        memReady = 1'b0;
        waitCnt--;
      end
    end else begin
      memReady = 1'b0;
    end
  end

  task automatic pushExp(input logic [31:0] a, input logic we, input logic [31:0] d);
    if (expN < LOG_MAX) begin
      expAddr[expN] = a;
      expWe[expN]   = we;
      expData[expN] = d;
    end
    expN++;
  endtask

  task automatic refFault(input logic wr, input logic us, input logic prot, input logic [31:0] va);
    expFault = 1'b1;
    expCode  = {us, wr, prot};
    expFaddr = va;
    {expR, expW, expX} = 3'b000;
  endtask

  function automatic logic refDeny(input logic u, input logic w, input logic us,
                                   input logic wr, input logic wp);
    if (us) return !u || (wr && !w);
    return wp && wr && !w;
  endfunction

  function automatic logic refMayWrite(input logic w, input logic us, input logic wp);
    if (us) return w;
    return !wp || w;
  endfunction

  // reference walk, independent of the design's structure
  task automatic refWalk(input logic [31:0] va, input logic wr, input logic us);
    logic [31:0] dA, tA, pde, pte, nv;
    logic u, w;
    expDone = 1'b0; expFault = 1'b0; expN = 0;
    if (!pagingOn) begin
      expDone = 1'b1;
      expPhys = va & a20Mask;
      {expR, expW, expX} = 3'b111;
      return;
    end
    dA  = ((dirBase & 32'hFFFFF000) + {20'd0, va[31:22], 2'b00}) & a20Mask;
    pde = refMem[widx(dA)];
    pushExp(dA, 1'b0, 32'h0);
    if (!pde[0]) begin refFault(wr, us, 1'b0, va); return; end
    if (pde[7] && largeOn) begin
      if (refDeny(pde[2], pde[1], us, wr, wpOn)) begin refFault(wr, us, 1'b1, va); return; end
      nv = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (nv != pde) begin pushExp(dA, 1'b1, nv); refMem[widx(dA)] = nv; end
      expDone = 1'b1;
      expPhys = {pde[31:22], va[21:0]} & a20Mask;
      {expR, expX} = 2'b11;
      expW = nv[6] & refMayWrite(pde[1], us, wpOn);
      return;
    end
    if (!pde[5]) begin
      nv = pde | 32'h20;
      pushExp(dA, 1'b1, nv);
      refMem[widx(dA)] = nv;
    end
    tA  = ((pde & 32'hFFFFF000) + {20'd0, va[21:12], 2'b00}) & a20Mask;
    pte = refMem[widx(tA)];
    pushExp(tA, 1'b0, 32'h0);
    if (!pte[0]) begin refFault(wr, us, 1'b0, va); return; end
    u = pde[2] & pte[2];
    w = pde[1] & pte[1];
    if (refDeny(u, w, us, wr, wpOn)) begin refFault(wr, us, 1'b1, va); return; end
    nv = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (nv != pte) begin pushExp(tA, 1'b1, nv); refMem[widx(tA)] = nv; end
    expDone = 1'b1;
    expPhys = {pte[31:12], va[11:0]} & a20Mask;
    {expR, expX} = 2'b11;
    expW = nv[6] & refMayWrite(w, us, wpOn);
  endtask

  task automatic setWord(input logic [31:0] a, input logic [31:0] d);
    mem[widx(a)]    = d;
    refMem[widx(a)] = d;
  endtask

  task automatic fillRandom();
    for (int i = 0; i < MEM_WORDS; i++) begin
      logic [31:0] wv;
      wv = $urandom;
      if (($urandom % 10) < 7) wv[0] = 1'b1;
      mem[i]    = wv;
      refMem[i] = wv;
    end
  endtask

  // one translation; called at a negative edge
  task automatic runOne(input logic [31:0] va, input logic wr, input logic us,
                        input bit hold, input string tag);
    int  n;
    bit  busyBad;
    logic gotDone, gotFault;
    refWalk(va, wr, us);
    reqAddr  = va;
    reqWrite = wr;
    reqUser  = us;
    reqValid = 1'b1;
    actN     = 0;
    busyBad  = 1'b0;
    @(negedge clk);
    if (!hold) reqValid = 1'b0;
    n = 0;
    while (!(done || fault) && n < 300) begin
      if (!busy) busyBad = 1'b1;
      if (!hold) reqAddr = $urandom;
      @(negedge clk);
      n++;
    end
    if (!busy) busyBad = 1'b1;
    gotDone  = done;
    gotFault = fault;
    reqValid = 1'b0;
    chk(n < 300, $sformatf("%s R11", tag), "walk finished", 32'(n), 32'd300);
    chk({gotDone, gotFault} == {expDone, expFault}, $sformatf("%s R4 R7", tag),
        "done/fault", {30'd0, gotDone, gotFault}, {30'd0, expDone, expFault});
    if (expDone && gotDone) begin
      chk(physAddr == expPhys, $sformatf("%s R5 R6", tag), "physAddr", physAddr, expPhys);
      chk({permRead, permWrite, permExec} == {expR, expW, expX}, $sformatf("%s R10", tag),
          "perm rwx", {29'd0, permRead, permWrite, permExec}, {29'd0, expR, expW, expX});
    end
    if (expFault && gotFault) begin
      chk(faultCode == expCode, $sformatf("%s R8", tag), "faultCode",
          {29'd0, faultCode}, {29'd0, expCode});
      chk(faultAddr == expFaddr, $sformatf("%s R8", tag), "faultAddr", faultAddr, expFaddr);
      chk({permRead, permWrite, permExec} == 3'b000, $sformatf("%s R8", tag),
          "perm after fault", {29'd0, permRead, permWrite, permExec}, 32'd0);
    end
    chk(actN == expN, $sformatf("%s R1 R9", tag), "access count", 32'(actN), 32'(expN));
    for (int i = 0; i < expN && i < actN && i < LOG_MAX; i++) begin
      chk(actAddr[i] == expAddr[i] && actWe[i] == expWe[i], $sformatf("%s R2 R3", tag),
          $sformatf("access %0d addr", i), actAddr[i], expAddr[i]);
      if (expWe[i])
        chk(actData[i] == expData[i], $sformatf("%s R9", tag),
            $sformatf("access %0d wdata", i), actData[i], expData[i]);
    end
    @(negedge clk);
    chk(!busy && !done && !fault, $sformatf("%s R11", tag), "idle after response",
        {29'd0, busy, done, fault}, 32'd0);
    chk(!busyBad, $sformatf("%s R11", tag), "busy during walk", 32'(busyBad), 32'd0);
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0; reqUser = 1'b0;
    pagingOn = 1'b1; wpOn = 1'b0; largeOn = 1'b1;
    dirBase = 32'h0000_1000; a20Mask = 32'hFFFF_FFFF;
    for (int i = 0; i < MEM_WORDS; i++) begin mem[i] = '0; refMem[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !memReq, "R11", "reset outputs",
        {28'd0, busy, done, fault, memReq}, 32'd0);

    // R1: paging off, mask clears bit 20
    pagingOn = 1'b0; a20Mask = 32'hFFEF_FFFF;
    runOne(32'h1234_5678, 1'b1, 1'b1, 0, "R1 flat");
    pagingOn = 1'b1; a20Mask = 32'hFFFF_FFFF;

    // R4: directory entry not present, user write
    setWord(32'h0000_1014, 32'h0);
    runOne({10'd5, 10'd3, 12'h0AB}, 1'b1, 1'b1, 0, "R4 dir absent");

    // R5: 4 MB page, accessed bit written back
    setWord(32'h0000_1040, 32'h8000_0087);
    runOne(32'h0412_3456, 1'b0, 1'b0, 0, "R5 large page");
    // R5: large pages disabled, bit 7 ignored
    largeOn = 1'b0;
    setWord(32'h0000_048C, 32'h0055_5007);
    runOne(32'h0412_3456, 1'b0, 1'b1, 0, "R5 large off");
    largeOn = 1'b1;

    // R7: user write to read-only table entry
    setWord(32'h0000_1080, 32'h0000_2027);
    setWord(32'h0000_201C, 32'h00AB_C005);
    runOne(32'h0800_7123, 1'b1, 1'b1, 0, "R7 user ro write");
    // R7: supervisor write, protection off
    wpOn = 1'b0;
    runOne(32'h0800_7123, 1'b1, 1'b0, 0, "R7 sup write wp off");
    // R7: supervisor write, protection on
    wpOn = 1'b1;
    setWord(32'h0000_201C, 32'h00AB_C005);
    runOne(32'h0800_7123, 1'b1, 1'b0, 0, "R7 sup write wp on");
    wpOn = 1'b0;

    // R10: clean page read gives no write permission; write dirties it
    setWord(32'h0000_2020, 32'h00DE_F007);
    runOne(32'h0800_8010, 1'b0, 1'b1, 0, "R10 clean read");
    runOne(32'h0800_8010, 1'b1, 1'b1, 0, "R10 dirtying write");
    runOne(32'h0800_8010, 1'b0, 1'b1, 0, "R10 dirty read");

    // R6: effective user bit is the AND of both levels
    setWord(32'h0000_1084, 32'h0000_3023);
    setWord(32'h0000_3000, 32'h0011_1067);
    runOne(32'h0840_0005, 1'b0, 1'b1, 0, "R6 and user");

    // R11: request held high during the walk is not taken twice
    runOne(32'h0800_8010, 1'b0, 1'b1, 1, "R11 held request");

    // R2: low base bits ignored
    dirBase = 32'h0000_1ABC;
    runOne(32'h0412_3456, 1'b1, 1'b0, 0, "R2 base low bits");
    dirBase = 32'h0000_1000;

    // random walks with stalls
    for (int k = 0; k < 400; k++) begin
      if (k % 80 == 0) fillRandom();
      pagingOn = ($urandom % 10) != 0;
      wpOn     = $urandom % 2;
      largeOn  = $urandom % 2;
      a20Mask  = (($urandom % 4) == 0) ? 32'hFFEF_FFFF : 32'hFFFF_FFFF;
      dirBase  = $urandom;
      runOne($urandom, 1'($urandom % 2), 1'($urandom % 2), 0, "R7 R12 random");
    end

    finish();
  end

endmodule